// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed RISC-V word into the 32-bit base-ISA instruction that does the same work. A decode stage uses it so that the rest of the pipeline handles only full-width encodings. The two low bits of the word select one of three quadrants. Within a quadrant, the three top bits select the operation.

Each compressed format spreads its immediate over scattered bit positions. The expander gathers those bits back into standard I, S, B, J and U immediates. It also maps each 3-bit compact register field onto x8 to x15.

Every word the block cannot expand is flagged illegal, and its 32-bit output is zero. This covers:
- the RV64-only forms and the floating-point forms;
- reserved encodings;
- words whose low bits mark a full-width instruction.

A parameter chooses between a purely combinational path and a single output register stage.

Top module: `rvc_expander`

## Requirements
- R1: A word whose bits [1:0] are 11 is flagged illegal, and so is the all-zero word. Whenever the illegal flag is high, `out_instr` is 32'h0000_0000.
- R2: A compact 3-bit register field r (at bits [4:2] or [9:7]) selects register 8+r in the expansion.
- R3: In quadrant 00, funct3 000 expands to `addi rd', x2, u`. Here u is zero-extended, and word bits 12:11 give u[5:4], bits 10:7 give u[9:6], bit 6 gives u[2] and bit 5 gives u[3]. If u is zero, the word is illegal.
- R4: Quadrant 00 funct3 010 expands to `lw rd', u(rs1')` and funct3 110 expands to `sw rs2', u(rs1')`. For both, bits 12:10 give u[5:3], bit 6 gives u[2] and bit 5 gives u[6].
- R5: Quadrant 01 funct3 001 expands to `jal x1, off` and funct3 101 expands to `jal x0, off`. The offset is sign-extended from bit 11. Word bits 12..2 carry offset bits 11,4,9,8,10,6,7,3,2,1,5 in that order.
- R6: Quadrant 01 funct3 011 with bits [11:7]=2 expands to `addi x2, x2, s`, where s is a multiple of 16 taken from bit 12 (s[9]) and bits 6..2 (s[4],s[6],s[8],s[7],s[5]). With any other rd it expands to `lui rd, v`, where v is sign-extended from bit 12 over bits 6:2. In either case, a zero immediate is illegal.
- R7: Quadrant 01 funct3 100 chooses on bits [11:10]:
  - 00 gives srli and 01 gives srai, both with shamt in bits [6:2];
  - 10 gives andi with a sign-extended 6-bit immediate;
  - 11 gives sub, xor, or or and, chosen by bits [6:5] = 00..11.
  A shift with bit 12 set is illegal, and the register group with bit 12 set is illegal.
- R8: Quadrant 01 funct3 110 expands to `beq rs1', x0, off` and funct3 111 expands to `bne rs1', x0, off`. Bit 12 gives off[8], bits 11:10 give off[4:3], bits 6:5 give off[7:6], bits 4:3 give off[2:1] and bit 2 gives off[5]. The offset is sign-extended.
- R9: Quadrant 10 funct3 100 decodes as follows:
  - bit12=0, rs2=0: `jalr x0, rs1, 0`, which is illegal when rs1 is 0;
  - bit12=0, rs2≠0: `add rd, x0, rs2`;
  - bit12=1 with both fields zero: `ebreak` (32'h0010_0073);
  - bit12=1, rs2=0: `jalr x1, rs1, 0`;
  - otherwise: `add rd, rd, rs2`.
- R10: Quadrant 10 funct3 010 expands to `lw rd, u(x2)`, with bit 12 giving u[5], bits 6:4 giving u[4:2] and bits 3:2 giving u[7:6]; rd=0 is illegal. Funct3 110 expands to `sw rs2, u(x2)`, with bits 12:9 giving u[5:2] and bits 8:7 giving u[7:6].
- R11: Quadrant 01 funct3 000 expands to `addi rd, rd, imm` (the word 16'h0001 gives 32'h0000_0013) and funct3 010 expands to `addi rd, x0, imm`. Quadrant 10 funct3 000 expands to `slli rd, rd, shamt`, which is illegal when bit 12 is set.
- R12: With the register stage enabled:
  - reset drives all three outputs to zero;
  - each output appears one clock after its input;
  - `out_valid` follows `in_valid`.
  The illegal flag is never high while `out_valid` is low, and reset wins over an input presented in the same cycle.
- R13: These reserved or unsupported encodings are illegal:
  - quadrant 00 with funct3 001, 011, 100, 101 or 111;
  - quadrant 10 with funct3 001, 011, 101 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The compressed word is present |
| in_word | input | 16 | Compressed instruction word |
| out_valid | output | 1 | The expansion is present |
| out_instr | output | 32 | Expanded 32-bit instruction, zero when illegal |
| out_illegal | output | 1 | The word cannot be expanded |

## Verification
Two things can land on the register stage in the same cycle: a reset, and the capture of a valid word that would raise the illegal flag. The bench drives the all-zero word with `in_valid` high in the same cycle that reset is asserted. One clock later it expects all outputs to be zero, with the illegal flag low. It also streams the vector table back to back, so that a legal expansion and an illegal one occupy neighbouring cycles. Each result is judged one clock after its word, which shows that no flag or stale bits leak from one word into the next.

// File: rtl/rvc_exp_pkg.sv
package rvc_exp_pkg;

    localparam int unsigned CW = 16;
    localparam int unsigned XW = 32;

    typedef enum logic [1:0] {
        QUAD_ZERO = 2'b00,
        QUAD_ONE  = 2'b01,
        QUAD_TWO  = 2'b10,
        QUAD_WIDE = 2'b11
    } quad_e;

    typedef enum logic [6:0] {
        OPC_LOAD   = 7'b0000011,
        OPC_OPIMM  = 7'b0010011,
        OPC_STORE  = 7'b0100011,
        OPC_OP     = 7'b0110011,
        OPC_LUI    = 7'b0110111,
        OPC_BRANCH = 7'b1100011,
        OPC_JALR   = 7'b1100111,
        OPC_JAL    = 7'b1101111,
        OPC_SYSTEM = 7'b1110011
    } opc_e;

    typedef logic [4:0] reg_t;

    typedef struct packed {
        logic          bad;
        logic [XW-1:0] word;
    } xlat_t;

    localparam reg_t REG_ZERO = 5'd0;
    localparam reg_t REG_RA   = 5'd1;
    localparam reg_t REG_SP   = 5'd2;
    localparam xlat_t XLAT_BAD = '{bad: 1'b1, word: '0};

    function automatic reg_t wide_reg(input logic [2:0] r);
        return {2'b01, r};
    endfunction

    function automatic xlat_t ok_xlat(input logic [XW-1:0] w);
        xlat_t x;
        x.bad  = 1'b0;
        x.word = w;
        return x;
    endfunction

    function automatic logic [XW-1:0] fmt_i(input logic [11:0] imm, input reg_t rs1,
                                            input logic [2:0] f3, input reg_t rd,
                                            input opc_e op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [XW-1:0] fmt_s(input logic [11:0] imm, input reg_t rs2,
                                            input reg_t rs1, input logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
    endfunction

    function automatic logic [XW-1:0] fmt_b(input logic [12:1] imm, input reg_t rs1,
                                            input logic [2:0] f3);
        return {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
    endfunction

    function automatic logic [XW-1:0] fmt_j(input logic [20:1] imm, input reg_t rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
    endfunction

    function automatic logic [XW-1:0] fmt_u(input logic [19:0] hi, input reg_t rd);
        return {hi, rd, OPC_LUI};
    endfunction

    function automatic logic [XW-1:0] fmt_r(input logic [6:0] f7, input reg_t rs2,
                                            input reg_t rs1, input logic [2:0] f3,
                                            input reg_t rd);
        return {f7, rs2, rs1, f3, rd, OPC_OP};
    endfunction

endpackage

// File: rtl/rvc_q0_dec.sv
module rvc_q0_dec
    import rvc_exp_pkg::*;
(
    input  logic [15:2] cw,
    output xlat_t       res
);
    logic [9:0] sp_ofs;
    logic [6:0] w_ofs;
    reg_t       r_lo;
    reg_t       r_hi;

    // Gather scattered immediate bits back into natural order.
    assign sp_ofs = {cw[10:7], cw[12:11], cw[5], cw[6], 2'b00};
    assign w_ofs  = {cw[5], cw[12:10], cw[6], 2'b00};
    assign r_lo   = wide_reg(cw[4:2]);
    assign r_hi   = wide_reg(cw[9:7]);

    always_comb begin
        res = XLAT_BAD;
        unique case (cw[15:13])
            3'b000: if (sp_ofs != '0)
                        res = ok_xlat(fmt_i({2'b00, sp_ofs}, REG_SP, 3'b000, r_lo, OPC_OPIMM));
            3'b010: res = ok_xlat(fmt_i({5'b0, w_ofs}, r_hi, 3'b010, r_lo, OPC_LOAD));
            3'b110: res = ok_xlat(fmt_s({5'b0, w_ofs}, r_lo, r_hi, 3'b010));
            default: res = XLAT_BAD;
        endcase
    end
endmodule

// File: rtl/rvc_q1_dec.sv
module rvc_q1_dec
    import rvc_exp_pkg::*;
(
    input  logic [15:2] cw,
    output xlat_t       res
);
    reg_t        rd_full;
    reg_t        r_lo;
    reg_t        r_hi;
    logic [5:0]  imm6;
    logic [11:0] imm_sx;
    logic [11:1] j_ofs;
    logic [8:1]  b_ofs;
    logic [9:4]  sp_ofs;

    assign rd_full = cw[11:7];
    assign r_lo    = wide_reg(cw[4:2]);
    assign r_hi    = wide_reg(cw[9:7]);
    assign imm6    = {cw[12], cw[6:2]};
    assign imm_sx  = {{6{imm6[5]}}, imm6};
    assign j_ofs   = {cw[12], cw[8], cw[10:9], cw[6], cw[7], cw[2], cw[11], cw[5:3]};
    assign b_ofs   = {cw[12], cw[6:5], cw[2], cw[11:10], cw[4:3]};
    assign sp_ofs  = {cw[12], cw[4:3], cw[5], cw[2], cw[6]};

    always_comb begin
        res = XLAT_BAD;
        unique case (cw[15:13])
            3'b000: res = ok_xlat(fmt_i(imm_sx, rd_full, 3'b000, rd_full, OPC_OPIMM));
            3'b001: res = ok_xlat(fmt_j({{9{j_ofs[11]}}, j_ofs}, REG_RA));
            3'b010: res = ok_xlat(fmt_i(imm_sx, REG_ZERO, 3'b000, rd_full, OPC_OPIMM));
            3'b011: begin
                if (rd_full == REG_SP) begin
                    if (sp_ofs != '0)
                        res = ok_xlat(fmt_i({{2{sp_ofs[9]}}, sp_ofs, 4'b0000},
                                            REG_SP, 3'b000, REG_SP, OPC_OPIMM));
                end else if (imm6 != '0) begin
                    res = ok_xlat(fmt_u({{14{imm6[5]}}, imm6}, rd_full));
                end
            end
            3'b100: begin
                unique case (cw[11:10])
                    2'b00: if (!cw[12])
                               res = ok_xlat(fmt_i({7'b0000000, cw[6:2]}, r_hi, 3'b101, r_hi, OPC_OPIMM));
                    2'b01: if (!cw[12])
                               res = ok_xlat(fmt_i({7'b0100000, cw[6:2]}, r_hi, 3'b101, r_hi, OPC_OPIMM));
                    2'b10: res = ok_xlat(fmt_i(imm_sx, r_hi, 3'b111, r_hi, OPC_OPIMM));
                    default: if (!cw[12]) begin
                        unique case (cw[6:5])
                            2'b00:   res = ok_xlat(fmt_r(7'b0100000, r_lo, r_hi, 3'b000, r_hi));
                            2'b01:   res = ok_xlat(fmt_r(7'b0000000, r_lo, r_hi, 3'b100, r_hi));
                            2'b10:   res = ok_xlat(fmt_r(7'b0000000, r_lo, r_hi, 3'b110, r_hi));
                            default: res = ok_xlat(fmt_r(7'b0000000, r_lo, r_hi, 3'b111, r_hi));
                        endcase
                    end
                endcase
            end
            3'b101: res = ok_xlat(fmt_j({{9{j_ofs[11]}}, j_ofs}, REG_ZERO));
            default: res = ok_xlat(fmt_b({{4{b_ofs[8]}}, b_ofs}, r_hi, {2'b00, cw[13]}));
        endcase
    end
endmodule

// File: rtl/rvc_q2_dec.sv
module rvc_q2_dec
    import rvc_exp_pkg::*;
(
    input  logic [15:2] cw,
    output xlat_t       res
);
    reg_t       rd;
    reg_t       rs2;
    logic [7:2] ld_ofs;
    logic [7:2] st_ofs;

    assign rd     = cw[11:7];
    assign rs2    = cw[6:2];
    assign ld_ofs = {cw[3:2], cw[12], cw[6:4]};
    assign st_ofs = {cw[8:7], cw[12:9]};

    always_comb begin
        res = XLAT_BAD;
        unique case (cw[15:13])
            3'b000: if (!cw[12])
                        res = ok_xlat(fmt_i({7'b0, rs2}, rd, 3'b001, rd, OPC_OPIMM));
            3'b010: if (rd != REG_ZERO)
                        res = ok_xlat(fmt_i({4'b0, ld_ofs, 2'b00}, REG_SP, 3'b010, rd, OPC_LOAD));
            3'b100: begin
                if (!cw[12]) begin
                    if (rs2 != REG_ZERO)
                        res = ok_xlat(fmt_r(7'b0, rs2, REG_ZERO, 3'b000, rd));
                    else if (rd != REG_ZERO)
                        res = ok_xlat(fmt_i(12'd0, rd, 3'b000, REG_ZERO, OPC_JALR));
                end else begin
                    if (rs2 != REG_ZERO)
                        res = ok_xlat(fmt_r(7'b0, rs2, rd, 3'b000, rd));
                    else if (rd != REG_ZERO)
                        res = ok_xlat(fmt_i(12'd0, rd, 3'b000, REG_RA, OPC_JALR));
                    else
                        res = ok_xlat(fmt_i(12'd1, REG_ZERO, 3'b000, REG_ZERO, OPC_SYSTEM));
                end
            end
            3'b110: res = ok_xlat(fmt_s({4'b0, st_ofs, 2'b00}, rs2, REG_SP, 3'b010));
            default: res = XLAT_BAD;
        endcase
    end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
    import rvc_exp_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [CW-1:0] in_word,
    output logic          out_valid,
    output logic [XW-1:0] out_instr,
    output logic          out_illegal
);
    xlat_t res_q0;
    xlat_t res_q1;
    xlat_t res_q2;
    xlat_t pick;
    quad_e quad;

    rvc_q0_dec i_q0 (.cw(in_word[15:2]), .res(res_q0));
    rvc_q1_dec i_q1 (.cw(in_word[15:2]), .res(res_q1));
    rvc_q2_dec i_q2 (.cw(in_word[15:2]), .res(res_q2));

    assign quad = quad_e'(in_word[1:0]);

    always_comb begin
        unique case (quad)
            QUAD_ZERO: pick = res_q0;
            QUAD_ONE:  pick = res_q1;
            QUAD_TWO:  pick = res_q2;
            default:   pick = XLAT_BAD;
        endcase
    end

    generate
        if (REGISTER_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid   <= 1'b0;
                    out_instr   <= '0;
                    out_illegal <= 1'b0;
                end else begin
                    out_valid   <= in_valid;
                    out_instr   <= pick.word;
                    out_illegal <= in_valid & pick.bad;
                end
            end

            AST_VALID_RISES: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid); // R12
            AST_VALID_FALLS: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid); // R12
            AST_WIDE_REJECT: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_word[1:0] == 2'b11) |=> out_illegal); // R1
            AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_word == '0) |=> (out_illegal && out_instr == '0)); // R1
            AST_JR_ZERO_REJECT: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_word == 16'h8002) |=> out_illegal); // R9
        end else begin : g_comb
            assign out_valid   = in_valid;
            assign out_instr   = pick.word;
            assign out_illegal = in_valid & pick.bad;
        end
    endgenerate

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_instr == '0); // R1
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_illegal); // R12
    AST_LEGAL_FULLWIDTH: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal) |-> out_instr[1:0] == 2'b11); // R2
endmodule

// File: tb/test_rvc_expander.sv
`timescale 1ns/1ps
module test_rvc_expander;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 55;

    typedef struct packed {
        logic [15:0] cw;
        logic [31:0] want;
        logic        bad;
        logic [3:0]  req;
    } vec_t;

    // Hand-computed vectors; req holds the requirement number.
    localparam vec_t VECS [NV] = '{
        '{16'h0040, 32'h00410413, 1'b0, 4'd3},   // R3 addi x8,x2,4
        '{16'h1FFC, 32'h3FC10793, 1'b0, 4'd3},   // R3 addi x15,x2,1020
        '{16'h0000, 32'h00000000, 1'b1, 4'd1},   // R1 all-zero
        '{16'h001C, 32'h00000000, 1'b1, 4'd3},   // R3 zero imm, rd'!=0
        '{16'h4144, 32'h00452483, 1'b0, 4'd4},   // R4 lw x9,4(x10)
        '{16'h5C60, 32'h07C42403, 1'b0, 4'd4},   // R4 lw x8,124(x8)
        '{16'hC22C, 32'h04B62023, 1'b0, 4'd4},   // R4 sw x11,64(x12)
        '{16'h3FFD, 32'hFFFFF0EF, 1'b0, 4'd5},   // R5 jal x1,-2
        '{16'hA801, 32'h0100006F, 1'b0, 4'd5},   // R5 jal x0,16
        '{16'hA005, 32'h0200006F, 1'b0, 4'd5},   // R5 jal x0,32
        '{16'h12FD, 32'hFFF28293, 1'b0, 4'd11},  // R11 addi x5,x5,-1
        '{16'h0001, 32'h00000013, 1'b0, 4'd11},  // R11 nop
        '{16'h457D, 32'h01F00513, 1'b0, 4'd11},  // R11 addi x10,x0,31
        '{16'h0092, 32'h00409093, 1'b0, 4'd11},  // R11 slli x1,x1,4
        '{16'h1092, 32'h00000000, 1'b1, 4'd11},  // R11 slli shamt5
        '{16'h717D, 32'hFF010113, 1'b0, 4'd6},   // R6 addi x2,x2,-16
        '{16'h6141, 32'h01010113, 1'b0, 4'd6},   // R6 addi x2,x2,16
        '{16'h6101, 32'h00000000, 1'b1, 4'd6},   // R6 zero sp adjust
        '{16'h6185, 32'h000011B7, 1'b0, 4'd6},   // R6 lui x3,1
        '{16'h71FD, 32'hFFFFF1B7, 1'b0, 4'd6},   // R6 lui x3,-1
        '{16'h6181, 32'h00000000, 1'b1, 4'd6},   // R6 zero lui
        '{16'h800D, 32'h00345413, 1'b0, 4'd7},   // R7 srli x8,3
        '{16'h900D, 32'h00000000, 1'b1, 4'd7},   // R7 srli shamt5
        '{16'h84FD, 32'h41F4D493, 1'b0, 4'd7},   // R7 srai x9,31
        '{16'h94FD, 32'h00000000, 1'b1, 4'd7},   // R7 srai shamt5
        '{16'h9979, 32'hFFE57513, 1'b0, 4'd7},   // R7 andi x10,-2
        '{16'h8C05, 32'h40940433, 1'b0, 4'd7},   // R7 sub x8,x9
        '{16'h8E35, 32'h00D64633, 1'b0, 4'd2},   // R2 xor x12,x13
        '{16'h8F5D, 32'h00F76733, 1'b0, 4'd2},   // R2 or x14,x15
        '{16'h8FE1, 32'h0087F7B3, 1'b0, 4'd7},   // R7 and x15,x8
        '{16'h9C05, 32'h00000000, 1'b1, 4'd7},   // R7 reg group bit12
        '{16'hDC7D, 32'hFE040FE3, 1'b0, 4'd8},   // R8 beq x8,-2
        '{16'hE481, 32'h00049463, 1'b0, 4'd8},   // R8 bne x9,8
        '{16'hE005, 32'h02041063, 1'b0, 4'd8},   // R8 bne x8,32
        '{16'h40B2, 32'h00C12083, 1'b0, 4'd10},  // R10 lw x1,12(x2)
        '{16'h408E, 32'h0C012083, 1'b0, 4'd10},  // R10 lw x1,192(x2)
        '{16'h4032, 32'h00000000, 1'b1, 4'd10},  // R10 lwsp rd=0
        '{16'hC416, 32'h00512423, 1'b0, 4'd10},  // R10 sw x5,8(x2)
        '{16'hDF82, 32'h0E012E23, 1'b0, 4'd10},  // R10 sw x0,252(x2)
        '{16'h8082, 32'h00008067, 1'b0, 4'd9},   // R9 jr x1
        '{16'h8002, 32'h00000000, 1'b1, 4'd9},   // R9 jr x0
        '{16'h852E, 32'h00B00533, 1'b0, 4'd9},   // R9 mv
        '{16'h9002, 32'h00100073, 1'b0, 4'd9},   // R9 ebreak
        '{16'h9282, 32'h000280E7, 1'b0, 4'd9},   // R9 jalr x1,x5
        '{16'h952E, 32'h00B50533, 1'b0, 4'd9},   // R9 add
        '{16'h2000, 32'h00000000, 1'b1, 4'd13},  // R13 q0 f3=001
        '{16'h6000, 32'h00000000, 1'b1, 4'd13},  // R13 q0 f3=011
        '{16'h8000, 32'h00000000, 1'b1, 4'd13},  // R13 q0 f3=100
        '{16'hA000, 32'h00000000, 1'b1, 4'd13},  // R13 q0 f3=101
        '{16'hE000, 32'h00000000, 1'b1, 4'd13},  // R13 q0 f3=111
        '{16'h2002, 32'h00000000, 1'b1, 4'd13},  // R13 q2 f3=001
        '{16'h6002, 32'h00000000, 1'b1, 4'd13},  // R13 q2 f3=011
        '{16'hA002, 32'h00000000, 1'b1, 4'd13},  // R13 q2 f3=101
        '{16'hE002, 32'h00000000, 1'b1, 4'd13},  // R13 q2 f3=111
        '{16'h0013, 32'h00000000, 1'b1, 4'd1}    // R1 full-width word
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_valid;
    logic [31:0] out_instr;
    logic        out_illegal;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    rvc_expander i_rvc_expander (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_instr(out_instr), .out_illegal(out_illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        // R12: reset state
        repeat (2) @(posedge clk);
        #2;
        check(out_valid == 1'b0 && out_illegal == 1'b0, "R12 reset flags",
              {30'd0, out_valid, out_illegal}, 32'd0);
        check(out_instr == 32'd0, "R12 reset instr", out_instr, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk, back to back; each result one clock after its word.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            in_word  = VECS[k].cw;
            in_valid = 1'b1;
            @(posedge clk);
            #2;
            check(out_valid && out_illegal == VECS[k].bad && out_instr == VECS[k].want,
                  $sformatf("R%0d word %04h ill=%0b", VECS[k].req, VECS[k].cw, out_illegal),
                  out_instr, VECS[k].want);
        end

        // R12: idle input never flags illegal, even for an all-zero word
        @(negedge clk);
        in_word  = 16'h0000;
        in_valid = 1'b0;
        @(posedge clk);
        #2;
        check(!out_valid && !out_illegal, "R12 idle no flag",
              {30'd0, out_valid, out_illegal}, 32'd0);

        // R12: one clock of latency; output holds until the edge
        @(negedge clk);
        in_word  = 16'h0001;
        in_valid = 1'b1;
        #2;
        check(!out_valid, "R12 latency before edge", {31'd0, out_valid}, 32'd0);
        @(posedge clk);
        #2;
        check(out_valid && out_instr == 32'h00000013, "R12 latency after edge",
              out_instr, 32'h00000013);

        // R12: reset together with a valid illegal word; reset wins
        @(negedge clk);
        in_word  = 16'h0000;
        in_valid = 1'b1;
        rst      = 1'b1;
        @(posedge clk);
        #2;
        check(!out_valid && !out_illegal && out_instr == 32'd0, "R12 reset collision",
              out_instr, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check(out_valid && out_illegal && out_instr == 32'd0, "R1 zero after reset",
              out_instr, 32'd0);

        // R1: all-ones word lies in the full-width quadrant
        @(negedge clk);
        in_word = 16'hFFFF;
        @(posedge clk);
        #2;
        check(out_illegal && out_instr == 32'd0, "R1 all-ones word", out_instr, 32'd0);

        @(negedge clk);
        in_valid = 1'b0;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule